// File: doc/BRIEF.md
# Interval Timer Down-Counter Channel with Count Snapshot

This block is a single 16-bit down-counting channel of a programmable interval timer, reached through a byte-wide host port. The host loads a count with two data-port writes, low byte first. The high-byte write transfers the assembled value into the live counter and starts the channel. From then on every `tick` pulse lowers the count by one. When the count reaches zero through a tick, the status byte reports the terminal condition in bit 5.

The host reads the count back as two bytes, low byte first. A control-port write with the snapshot access code freezes the current count in a holding register. The next two data reads then return the frozen value instead of the live one. Further snapshot commands have no effect until both frozen bytes have been read. Control words that select the low-then-high access mode are accepted. Every other access code, and the read-back select value, is reported on a one-cycle `unsup_cmd` flag and changes nothing.

All inputs are sampled on the rising clock edge. `rd_data` and `unsup_cmd` are registered, so they are valid in the cycle after the access.

Top module: `down_timer_chan`

## Requirements
- R1: After reset the count is 0x0000, the status byte reads 0x00, no snapshot is pending, both byte pointers point at the low byte and `unsup_cmd` is 0.
- R2: A data write (`wr_en`=1, `wr_sel`=0) stores a low byte. The following data write supplies the high byte and loads {high, low} into the live count. The count does not change on the low-byte write. The high-byte write clears the status byte to 0x00 and starts the channel.
- R3: Once the channel has been started, every cycle with `tick`=1 lowers the count by one, and a tick at 0x0000 wraps the count to 0xFFFF. Before the first load, ticks leave the count unchanged. A load in the same cycle as a tick takes priority.
- R4: When a tick moves the count from 0x0001 to 0x0000, the status byte (`rd_sel`=1) becomes 0x20, with bit 5 as the terminal flag. The status byte stays 0x20 through a later wrap and is cleared only by a load or by reset. Status reads have no side effects.
- R5: A control write (`wr_sel`=1) with bits [5:4]=00 and bits [7:6] equal to `CHAN_ID` is a snapshot command. It copies the current count into the holding register, marks a snapshot pending and returns the read pointer to the low byte, even if a live read had left the pointer on the high byte.
- R6: While a snapshot is pending, the first data read returns the held low byte and the second returns the held high byte. The second read clears the pending snapshot, so later reads show the live count again.
- R7: A snapshot command that arrives while a snapshot is pending is ignored, and the earlier held value is still the one read back.
- R8: With no snapshot pending, each data read returns the live count, alternating low byte and high byte. The read pointer toggles on every data read.
- R9: A control write with bits [5:4]=11 and bits [7:6] equal to `CHAN_ID` is accepted without raising `unsup_cmd`. It resets the load sequence so that the next data write is taken as a low byte.
- R10: A control write with bits [5:4]=01 or 10, or with bits [7:6]=11, drives `unsup_cmd` high for the one cycle after the write. It leaves the count, the snapshot and the pointers unchanged.
- R11: A snapshot command whose bits [7:6] select another channel (0, 1 or 2 but not `CHAN_ID`) does not freeze the count and raises no `unsup_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick, one decrement per cycle high |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 data port, 1 control port |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | Read source: 0 data port (count bytes), 1 status byte |
| rd_data | output | 8 | Read byte, registered, valid the cycle after `rd_en` |
| unsup_cmd | output | 1 | One-cycle flag for an unsupported control word |

## Verification
The hardest situation to reach from the ports is a snapshot that has to override a read pointer a live read left on the high byte. A second snapshot must also be shown to be swallowed while ticks keep moving the live count away from the held value. The stimulus does a single odd live read and then issues the snapshot. It ticks so that the live and held values differ, issues a redundant snapshot, and checks that the held bytes come back low first and are followed by the live count. Expiry and wrap are reached by reloading a count of three after a half-finished load sequence has been reset through an accepted control word.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int TERM_BIT = 5;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_LOHI = 2'b11
    } access_e;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    typedef struct packed {
        logic [1:0] sel;
        access_e    acc;
        logic [3:0] mode;
    } ctrl_word_t;

    typedef struct packed {
        logic snap;
        logic lohi;
        logic unsup;
    } ctrl_cmd_t;

    localparam logic [1:0] SEL_READBACK = 2'b11;

    function automatic ctrl_cmd_t decode_ctrl(input ctrl_word_t w, input logic [1:0] chan);
        ctrl_cmd_t c;
        c = '0;
        if (w.sel == SEL_READBACK) begin
            c.unsup = 1'b1;
        end else begin
            case (w.acc)
                ACC_SNAP: c.snap  = (w.sel == chan);
                ACC_LOHI: c.lohi  = (w.sel == chan);
                default:  c.unsup = 1'b1;
            endcase
        end
        return c;
    endfunction

    function automatic byte_ptr_e flip_ptr(input byte_ptr_e p);
        return (p == PTR_LO) ? PTR_HI : PTR_LO;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v, input byte_ptr_e p);
        return (p == PTR_LO) ? v[BYTE_W-1:0] : v[CNT_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/timer_ctrl_decode.sv
module timer_ctrl_decode
    import timer_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output logic              snap_hit,
    output logic              lohi_hit,
    output logic              unsup_hit
);

    ctrl_cmd_t cmd;

    always_comb begin
        cmd = decode_ctrl(ctrl_word_t'(ctrl_byte), CHAN_ID);
        snap_hit  = ctrl_wr & cmd.snap;
        lohi_hit  = ctrl_wr & cmd.lohi;
        unsup_hit = ctrl_wr & cmd.unsup;
    end

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              lohi_hit,
    output logic [CNT_W-1:0]  count,
    output logic              term,
    output logic              running,
    output logic              load_hi
);

    logic [BYTE_W-1:0] lo_byte_q;
    byte_ptr_e         wptr_q;
    logic              dec_en;

    always_comb begin
        load_hi = data_wr & ~lohi_hit & (wptr_q == PTR_HI);
        dec_en  = running & tick & ~load_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            lo_byte_q <= '0;
            wptr_q    <= PTR_LO;
            running   <= 1'b0;
            term      <= 1'b0;
        end else begin
            if (lohi_hit) begin
                wptr_q <= PTR_LO;
            end else if (data_wr) begin
                if (wptr_q == PTR_LO) begin
                    lo_byte_q <= data_byte;
                    wptr_q    <= PTR_HI;
                end else begin
                    count   <= {data_byte, lo_byte_q};
                    wptr_q  <= PTR_LO;
                    running <= 1'b1;
                    term    <= 1'b0;
                end
            end
            if (dec_en) begin
                count <= count - CNT_W'(1);
                if (count == CNT_W'(1)) begin
                    term <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/timer_snap_reader.sv
module timer_snap_reader
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snap_hit,
    input  logic              data_rd,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  hold,
    output logic              pend,
    output byte_ptr_e         rptr,
    output logic [BYTE_W-1:0] byte_out
);

    always_comb begin
        byte_out = pick_byte(pend ? hold : count, rptr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            pend <= 1'b0;
            rptr <= PTR_LO;
        end else begin
            if (data_rd) begin
                rptr <= flip_ptr(rptr);
                if (pend && rptr == PTR_HI) begin
                    pend <= 1'b0;
                end
            end
            if (snap_hit && !pend) begin
                hold <= count;
                pend <= 1'b1;
                rptr <= PTR_LO;
            end
        end
    end

endmodule

// File: rtl/down_timer_chan.sv
module down_timer_chan
    import timer_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              unsup_cmd
);

    logic              ctrl_wr;
    logic              data_wr;
    logic              data_rd;
    logic              snap_hit;
    logic              lohi_hit;
    logic              unsup_hit;
    logic [CNT_W-1:0]  count_q;
    logic              term_q;
    logic              running_q;
    logic              load_hi;
    logic [CNT_W-1:0]  hold_q;
    logic              snap_pend;
    byte_ptr_e         rptr_q;
    logic [BYTE_W-1:0] count_byte;
    logic [BYTE_W-1:0] status_byte;

    always_comb begin
        ctrl_wr = wr_en & wr_sel;
        data_wr = wr_en & ~wr_sel;
        data_rd = rd_en & ~rd_sel;
        status_byte = '0;
        status_byte[TERM_BIT] = term_q;
    end

    timer_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_decode (
        .ctrl_wr   (ctrl_wr),
        .ctrl_byte (wr_data),
        .snap_hit  (snap_hit),
        .lohi_hit  (lohi_hit),
        .unsup_hit (unsup_hit)
    );

    timer_count_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .data_wr   (data_wr),
        .data_byte (wr_data),
        .lohi_hit  (lohi_hit),
        .count     (count_q),
        .term      (term_q),
        .running   (running_q),
        .load_hi   (load_hi)
    );

    timer_snap_reader u_reader (
        .clk      (clk),
        .rst      (rst),
        .snap_hit (snap_hit),
        .data_rd  (data_rd),
        .count    (count_q),
        .hold     (hold_q),
        .pend     (snap_pend),
        .rptr     (rptr_q),
        .byte_out (count_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            unsup_cmd <= 1'b0;
        end else begin
            unsup_cmd <= unsup_hit;
            if (rd_en) begin
                rd_data <= rd_sel ? status_byte : count_byte;
            end
        end
    end

endmodule

// File: rtl/down_timer_chk.sv
module down_timer_chk
    import timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              unsup_cmd,
    input logic [CNT_W-1:0]  count_q,
    input logic              term_q,
    input logic              running_q,
    input logic              load_hi,
    input logic [CNT_W-1:0]  hold_q,
    input logic              snap_pend,
    input logic              snap_hit,
    input logic              data_rd,
    input byte_ptr_e         rptr_q
);

    p_load_high_r2: assert property (@(posedge clk) disable iff (rst)
        load_hi |=> (count_q[CNT_W-1:BYTE_W] == $past(wr_data)) && !term_q);

    p_tick_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (running_q && tick && !load_hi) |=> (count_q == $past(count_q) - CNT_W'(1)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !load_hi) |=> $stable(count_q));

    p_term_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(term_q) |-> (count_q == '0));

    p_snap_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (snap_pend && snap_hit) |=> $stable(hold_q));

    p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (snap_pend && data_rd && rptr_q == PTR_HI) |=> !snap_pend);

    p_readback_unsup_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data[7:6] == 2'b11) |=> unsup_cmd);

endmodule

bind down_timer_chan down_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .unsup_cmd (unsup_cmd),
    .count_q   (count_q),
    .term_q    (term_q),
    .running_q (running_q),
    .load_hi   (load_hi),
    .hold_q    (hold_q),
    .snap_pend (snap_pend),
    .snap_hit  (snap_hit),
    .data_rd   (data_rd),
    .rptr_q    (rptr_q)
);

// File: tb/test_down_timer_chan.sv
module test_down_timer_chan;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       unsup_cmd;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    down_timer_chan #(.CHAN_ID(2'd0)) i_down_timer_chan (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .unsup_cmd(unsup_cmd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic sel, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_byte(input logic sel, output logic [7:0] b);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        b = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic read_pair(input string req, input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] b;
        rd_byte(1'b0, b); check(req, b, lo);
        rd_byte(1'b0, b); check(req, b, hi);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] b;
        rd_byte(1'b1, b); check(req, b, exp);
    endtask

    task automatic t_reset;
        check("R1 unsup", {7'd0, unsup_cmd}, 8'h00);
        read_status("R1 status", 8'h00);
        read_pair("R1 count", 8'h00, 8'h00);
        ticks(3);
        read_pair("R3 no tick before load", 8'h00, 8'h00);
    endtask

    task automatic t_load;
        wr_byte(1'b0, 8'h34);
        read_pair("R2 low write alone", 8'h00, 8'h00);
        wr_byte(1'b0, 8'h12);
        read_pair("R2 loaded", 8'h34, 8'h12);
        read_status("R2 status clear", 8'h00);
    endtask

    task automatic t_tick;
        ticks(5);
        read_pair("R3 decrement", 8'h2F, 8'h12);
    endtask

    task automatic t_snapshot;
        wr_byte(1'b1, 8'h00);
        ticks(3);
        wr_byte(1'b1, 8'h00);
        read_pair("R6 R7 held value", 8'h2F, 8'h12);
        read_pair("R8 live after snapshot", 8'h2C, 8'h12);
    endtask

    task automatic t_ptr_override;
        logic [7:0] b;
        rd_byte(1'b0, b); check("R8 odd live read", b, 8'h2C);
        wr_byte(1'b1, 8'h00);
        ticks(2);
        read_pair("R5 pointer back to low", 8'h2C, 8'h12);
        read_pair("R8 live", 8'h2A, 8'h12);
    endtask

    task automatic t_other_chan;
        wr_byte(1'b1, 8'h80);
        check("R11 no unsup", {7'd0, unsup_cmd}, 8'h00);
        ticks(1);
        read_pair("R11 not frozen", 8'h29, 8'h12);
    endtask

    task automatic t_unsup;
        wr_byte(1'b1, 8'h10);
        check("R10 access 01", {7'd0, unsup_cmd}, 8'h01);
        @(negedge clk);
        check("R10 one cycle", {7'd0, unsup_cmd}, 8'h00);
        wr_byte(1'b1, 8'h20);
        check("R10 access 10", {7'd0, unsup_cmd}, 8'h01);
        wr_byte(1'b1, 8'hC0);
        check("R10 readback", {7'd0, unsup_cmd}, 8'h01);
        wr_byte(1'b1, 8'h30);
        check("R9 lohi accepted", {7'd0, unsup_cmd}, 8'h00);
        read_pair("R10 state kept", 8'h29, 8'h12);
    endtask

    task automatic t_seq_reset;
        wr_byte(1'b0, 8'h55);
        wr_byte(1'b1, 8'h30);
        wr_byte(1'b0, 8'h03);
        wr_byte(1'b0, 8'h00);
        read_pair("R9 load restarted", 8'h03, 8'h00);
    endtask

    task automatic t_expiry;
        ticks(2);
        read_status("R4 not yet", 8'h00);
        ticks(1);
        read_status("R4 terminal", 8'h20);
        read_pair("R4 zero", 8'h00, 8'h00);
        ticks(1);
        read_pair("R3 wrap", 8'hFF, 8'hFF);
        read_status("R4 sticky", 8'h20);
        wr_byte(1'b0, 8'h00);
        wr_byte(1'b0, 8'h01);
        read_status("R2 reload clears", 8'h00);
        read_pair("R2 reload value", 8'h00, 8'h01);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_tick();
        t_snapshot();
        t_ptr_override();
        t_other_chan();
        t_unsup();
        t_seq_reset();
        t_expiry();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule